// File: doc/BRIEF.md
# Sequence-Armed Watchdog Timer

This block is a watchdog that stays off after reset and counts only once software has written a fixed two-byte unlock pair to its service port. When armed, it advances a counter once per machine-cycle tick. If software does not write the same pair again before the counter runs out, the block raises a reset output for a fixed number of clock periods. It also sets a sticky overflow flag. The watchdog has no disarm write. Only a hardware reset, or its own overflow, returns it to the disabled state.

Two inputs can freeze the count. A power-down indication freezes it at all times. An idle indication freezes it only when the idle-stop configuration bit is set. A reset-output disable input suppresses the outgoing pulse, but the overflow flag is still set. The service port is write-only. The counter value cannot be observed or loaded.

Top module: `seq_watchdog`

## Requirements
- R1: After `rst_n` is sampled low, the watchdog is disarmed and `wdt_rst_o` and `ovf_flag_o` are 0. While disarmed, `mc_tick` has no effect and no pulse is produced.
- R2: A service write of `KEY_A` (default 8'h1E), followed by a service write of `KEY_B` (default 8'hE1) as the very next service write, arms the watchdog. Cycles without a write may separate the two writes.
- R3: Once armed, the watchdog overflows on the clock edge that carries the (2^CNT_W − 1)-th counted tick after the last arming or service pair. With the default CNT_W of 14, this is the 16383rd tick. `wdt_rst_o` is high from the next cycle on.
- R4: While armed, a complete `KEY_A`, `KEY_B` pair restarts the count from zero. A pair completed on the same edge as a tick takes priority over that tick.
- R5: Any service write other than `KEY_B` directly after a `KEY_A` write cancels the partial pair, and the count is not restarted. A cancelling write that is itself `KEY_A` begins a new partial pair. A `KEY_B` write with no pending `KEY_A` does nothing.
- R6: No service write disarms the watchdog. An overflow disarms it, and after that no further pulse occurs until it is armed again.
- R7: Each overflow drives `wdt_rst_o` high for exactly PULSE_LEN consecutive clock cycles (default 98).
- R8: While `pwr_down` is high, counted ticks are ignored and the count is held.
- R9: While `idle` is high, the count advances normally if `idle_stop` is 0. If `idle_stop` is 1, the count is held, and counting resumes from the held value when `idle` falls.
- R10: When `rst_out_dis` is 1 at overflow, `wdt_rst_o` stays low. `ovf_flag_o` is set on every overflow and is cleared only by `rst_n`.
- R11: The count advances only on cycles where `mc_tick` is high. Cycles without a tick leave it unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock (one oscillator period per cycle) |
| rst_n | input | 1 | Synchronous active-low hardware reset |
| mc_tick | input | 1 | Machine-cycle enable, one pulse per machine cycle |
| svc_wr | input | 1 | Service register write strobe |
| svc_data | input | DATA_W | Service register write data |
| idle | input | 1 | Core is in idle |
| pwr_down | input | 1 | Core is in power-down |
| idle_stop | input | 1 | 1 = hold the count during idle |
| rst_out_dis | input | 1 | 1 = suppress the reset pulse on overflow |
| wdt_rst_o | output | 1 | Watchdog reset pulse |
| ovf_flag_o | output | 1 | Sticky overflow status |

## Verification
The bench counts the effective ticks it presents under several mixes of tick gaps, idle windows with and without idle-stop, and power-down gaps. On every cycle it requires the reset output to be low before the terminal tick and high exactly one cycle after it. A design that overflows one tick late or early, or that counts during a freeze, fails at a specific cycle. Sequence corner cases are covered:
- reversed key order,
- a foreign byte between the keys,
- a repeated first key,
- attempted disarm writes while counting.

A decoder that accepts stale halves, or that lets a write clear the armed state, either pulses when it should not or misses the expected pulse. Pulse length, suppression with the flag still set, staying disarmed after overflow, and the flag clearing on hardware reset are each checked directly at the ports.

// File: rtl/wdt_pkg.sv
// Package: shared types for the sequence-armed watchdog.
// Assumes: nothing beyond IEEE 1800-2017.
package wdt_pkg;

    // Progress through the two-byte unlock pair
    typedef enum logic {
        SEQ_EMPTY = 1'b0,   // no first key pending
        SEQ_HALF  = 1'b1    // first key seen, second key expected next
    } seq_state_e;

endpackage

// File: rtl/wdt_unlock.sv
// Module: wdt_unlock
// Decodes service writes into a one-cycle kick when the first key is
// followed by the second key as the very next write.
// Assumes: svc_data is valid whenever svc_wr is high.
module wdt_unlock
    import wdt_pkg::*;
#(
    parameter int          DATA_W = 8,
    parameter logic [7:0]  KEY_A  = 8'h1E,
    parameter logic [7:0]  KEY_B  = 8'hE1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              svc_wr,
    input  logic [DATA_W-1:0] svc_data,
    output logic              kick
);

    localparam logic [DATA_W-1:0] KA = DATA_W'(KEY_A);
    localparam logic [DATA_W-1:0] KB = DATA_W'(KEY_B);

    seq_state_e seq_q;

    // Second key completing a pending pair
    always_comb kick = svc_wr && (seq_q == SEQ_HALF) && (svc_data == KB);

    // Track whether the previous write was the first key
    always_ff @(posedge clk) begin
        if (!rst_n)
            seq_q <= SEQ_EMPTY;
        else if (svc_wr) begin
            if (kick)
                seq_q <= SEQ_EMPTY;
            else if (svc_data == KA)
                seq_q <= SEQ_HALF;
            else
                seq_q <= SEQ_EMPTY;
        end
    end

    // A completed pair always leaves no half pending
    p_kick_consumes_r5: assert property (@(posedge clk) disable iff (!rst_n)
        kick |=> (seq_q == SEQ_EMPTY));

    // Cycles without a write keep the partial state
    p_seq_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !svc_wr |=> $stable(seq_q));

endmodule

// File: rtl/wdt_counter.sv
// Module: wdt_counter
// Holds the armed state and the hidden tick counter; flags overflow on
// the edge carrying the last tick before the all-ones value.
// Assumes: kick is a single-cycle strobe from the unlock decoder.
module wdt_counter #(
    parameter int CNT_W = 14
) (
    input  logic clk,
    input  logic rst_n,
    input  logic kick,
    input  logic mc_tick,
    input  logic idle,
    input  logic pwr_down,
    input  logic idle_stop,
    output logic ovf_evt
);

    localparam logic [CNT_W-1:0] LAST = {CNT_W{1'b1}} - CNT_W'(1);

    logic             armed_q;
    logic [CNT_W-1:0] cnt_q;
    logic             run;

    // A tick counts when armed and no freeze condition applies
    always_comb run = armed_q && mc_tick && !pwr_down && !(idle && idle_stop);

    // Overflow on the tick that would reach the all-ones value
    always_comb ovf_evt = run && !kick && (cnt_q == LAST);

    // Arm/restart on kick, disarm on overflow, else advance
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            armed_q <= 1'b0;
            cnt_q   <= '0;
        end else if (kick) begin
            armed_q <= 1'b1;
            cnt_q   <= '0;
        end else if (ovf_evt) begin
            armed_q <= 1'b0;
            cnt_q   <= '0;
        end else if (run) begin
            cnt_q   <= cnt_q + CNT_W'(1);
        end
    end

    p_kick_restart_r4: assert property (@(posedge clk) disable iff (!rst_n)
        kick |=> (armed_q && cnt_q == '0));

    p_pd_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (pwr_down && !kick && !ovf_evt) |=> $stable(cnt_q));

    p_idle_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (idle && idle_stop && !kick && !ovf_evt) |=> $stable(cnt_q));

    p_no_tick_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (!mc_tick && !kick) |=> $stable(cnt_q));

    p_disarm_on_ovf_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf_evt && !kick) |=> !armed_q);

    p_stay_armed_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (armed_q && !ovf_evt) |=> armed_q);

    p_idle_zero_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !armed_q |-> (cnt_q == '0));

endmodule

// File: rtl/wdt_pulse.sv
// Module: wdt_pulse
// Stretches an overflow event into a fixed-length reset pulse and keeps
// a sticky overflow flag.
// Assumes: ovf_evt is a single-cycle strobe.
module wdt_pulse #(
    parameter int PULSE_LEN = 98
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ovf_evt,
    input  logic rst_out_dis,
    output logic rst_o,
    output logic flag_o
);

    localparam int PW = $clog2(PULSE_LEN + 1);

    logic [PW-1:0] left_q;
    logic          flag_q;

    // Load the pulse length on an unsuppressed overflow, then count down
    always_ff @(posedge clk) begin
        if (!rst_n)
            left_q <= '0;
        else if (ovf_evt && !rst_out_dis)
            left_q <= PW'(PULSE_LEN);
        else if (left_q != '0)
            left_q <= left_q - PW'(1);
    end

    // Sticky status set by any overflow
    always_ff @(posedge clk) begin
        if (!rst_n)
            flag_q <= 1'b0;
        else if (ovf_evt)
            flag_q <= 1'b1;
    end

    always_comb rst_o  = (left_q != '0);
    always_comb flag_o = flag_q;

    p_pulse_cause_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_o) |-> $past(ovf_evt));

    p_suppress_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (!rst_o && ovf_evt && rst_out_dis) |=> !rst_o);

    p_flag_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
        flag_o |=> flag_o);

endmodule

// File: rtl/seq_watchdog.sv
// Module: seq_watchdog (top)
// Watchdog armed and serviced by an ordered two-byte write pair; counts
// machine-cycle ticks and emits a timed reset pulse on overflow.
// Assumes: clk is the oscillator clock; mc_tick marks machine cycles.
module seq_watchdog #(
    parameter int         DATA_W    = 8,
    parameter int         CNT_W     = 14,
    parameter int         PULSE_LEN = 98,
    parameter logic [7:0] KEY_A     = 8'h1E,
    parameter logic [7:0] KEY_B     = 8'hE1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mc_tick,
    input  logic              svc_wr,
    input  logic [DATA_W-1:0] svc_data,
    input  logic              idle,
    input  logic              pwr_down,
    input  logic              idle_stop,
    input  logic              rst_out_dis,
    output logic              wdt_rst_o,
    output logic              ovf_flag_o
);

    logic kick;
    logic ovf_evt;

    wdt_unlock #(
        .DATA_W (DATA_W),
        .KEY_A  (KEY_A),
        .KEY_B  (KEY_B)
    ) u_unlock (
        .clk      (clk),
        .rst_n    (rst_n),
        .svc_wr   (svc_wr),
        .svc_data (svc_data),
        .kick     (kick)
    );

    wdt_counter #(
        .CNT_W (CNT_W)
    ) u_counter (
        .clk       (clk),
        .rst_n     (rst_n),
        .kick      (kick),
        .mc_tick   (mc_tick),
        .idle      (idle),
        .pwr_down  (pwr_down),
        .idle_stop (idle_stop),
        .ovf_evt   (ovf_evt)
    );

    wdt_pulse #(
        .PULSE_LEN (PULSE_LEN)
    ) u_pulse (
        .clk         (clk),
        .rst_n       (rst_n),
        .ovf_evt     (ovf_evt),
        .rst_out_dis (rst_out_dis),
        .rst_o       (wdt_rst_o),
        .flag_o      (ovf_flag_o)
    );

    p_reset_quiet_r1: assert property (@(posedge clk)
        !rst_n |=> (!wdt_rst_o && !ovf_flag_o));

endmodule

// File: tb/tb_seq_watchdog.sv
module tb_seq_watchdog;

    localparam int CW    = 4;
    localparam int PL    = 6;
    localparam int MAXT  = (1 << CW) - 1;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       mc_tick = 1'b0;
    logic       svc_wr = 1'b0;
    logic [7:0] svc_data = 8'h00;
    logic       idle = 1'b0;
    logic       pwr_down = 1'b0;
    logic       idle_stop = 1'b0;
    logic       rst_out_dis = 1'b0;
    logic       wdt_rst_o;
    logic       ovf_flag_o;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    seq_watchdog #(
        .DATA_W (8), .CNT_W (CW), .PULSE_LEN (PL),
        .KEY_A (8'h1E), .KEY_B (8'hE1)
    ) dut (
        .clk (clk), .rst_n (rst_n), .mc_tick (mc_tick),
        .svc_wr (svc_wr), .svc_data (svc_data), .idle (idle),
        .pwr_down (pwr_down), .idle_stop (idle_stop),
        .rst_out_dis (rst_out_dis), .wdt_rst_o (wdt_rst_o),
        .ovf_flag_o (ovf_flag_o)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic quiet();
        mc_tick = 0; idle = 0; pwr_down = 0; idle_stop = 0; svc_wr = 0;
    endtask

    task automatic hw_reset();
        @(negedge clk); quiet(); rst_n = 0;
        @(negedge clk); @(negedge clk); rst_n = 1;
    endtask

    task automatic wr(input logic [7:0] d);
        @(negedge clk); mc_tick = 0; svc_wr = 1; svc_data = d;
        @(negedge clk); svc_wr = 0;
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); mc_tick = 1;
        end
        @(negedge clk); mc_tick = 0;
    endtask

    // Tick for n cycles and require no pulse
    task automatic no_pulse(input int n, input string req);
        bit seen = 0;
        for (int i = 0; i < n; i++) begin
            mc_tick = 1;
            @(negedge clk);
            if (wdt_rst_o) seen = 1;
        end
        mc_tick = 0;
        check(!seen, req, seen, 0);
    endtask

    // Drive a tick pattern; require rst low until eff reaches MAXT, then
    // high, then measure pulse length
    task automatic run_ovf(input int mode, input int start_eff, input string req);
        int eff = start_eff;
        bit bad = 0;
        int len;
        for (int cyc = 0; cyc < 400; cyc++) begin
            bit e;
            case (mode)
                0: begin mc_tick = 1; e = 1; end
                1: begin mc_tick = cyc[0]; e = cyc[0]; end
                2: begin mc_tick = 1; idle_stop = 1; idle = (cyc % 3 == 0); e = !idle; end
                3: begin mc_tick = 1; idle_stop = 0; idle = 1; e = 1; end
                default: begin mc_tick = 1; pwr_down = cyc[0]; e = !pwr_down; end
            endcase
            if (e) eff++;
            @(negedge clk);
            if (wdt_rst_o != (eff >= MAXT)) begin
                bad = 1;
                check(0, req, int'(wdt_rst_o), int'(eff >= MAXT));
                break;
            end
            if (eff >= MAXT) break;
        end
        quiet();
        if (!bad) check(1, req, 1, 1);
        len = 0;
        if (wdt_rst_o) begin
            len = 1;
            for (int k = 0; k < PL + 4; k++) begin
                @(negedge clk);
                if (wdt_rst_o) len++; else break;
            end
        end
        check(len == PL, "R7 pulse length", len, PL);
    endtask

    initial begin
        #600000;
        errors++;
        $display("FAIL watchdog timeout actual=running expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        hw_reset();
        @(negedge clk);
        check(!wdt_rst_o && !ovf_flag_o, "R1 reset state", wdt_rst_o, 0);
        no_pulse(40, "R1 disarmed ticks");

        // Reversed order, then foreign byte between keys
        wr(8'hE1); wr(8'h1E);
        no_pulse(40, "R5 reversed order");
        wr(8'h55); wr(8'hE1);
        no_pulse(40, "R5 foreign byte cancels");

        // Arm with idle cycles between the keys
        wr(8'h1E); repeat (3) @(negedge clk); wr(8'hE1);
        run_ovf(0, 0, "R2 R3 arm and continuous ticks");
        check(ovf_flag_o == 1, "R10 flag set", ovf_flag_o, 1);
        no_pulse(3 * MAXT, "R6 disarmed after overflow");

        // Service restarts
        wr(8'h1E); wr(8'hE1); ticks(10);
        wr(8'h1E); wr(8'hE1);
        run_ovf(0, 0, "R4 service restart");

        // Partial service does not restart
        wr(8'h1E); wr(8'hE1); ticks(10);
        wr(8'h1E); wr(8'h00); wr(8'hE1);
        run_ovf(0, 10, "R5 partial service ignored");

        // Repeated first key still completes
        wr(8'h1E); wr(8'h1E); wr(8'hE1);
        run_ovf(0, 0, "R5 repeated first key");

        // Disarm attempts
        wr(8'h1E); wr(8'hE1); ticks(5);
        wr(8'h00); wr(8'hE1); wr(8'h1E); wr(8'h55); wr(8'hFF);
        run_ovf(0, 5, "R6 writes cannot disarm");

        // Freeze patterns
        wr(8'h1E); wr(8'hE1); run_ovf(1, 0, "R11 sparse ticks");
        wr(8'h1E); wr(8'hE1); run_ovf(2, 0, "R9 idle with idle_stop=1");
        wr(8'h1E); wr(8'hE1); run_ovf(3, 0, "R9 idle with idle_stop=0");
        wr(8'h1E); wr(8'hE1); run_ovf(4, 0, "R8 power-down gaps");

        // Suppressed pulse with flag
        hw_reset();
        @(negedge clk);
        check(ovf_flag_o == 0, "R10 flag cleared by reset", ovf_flag_o, 0);
        rst_out_dis = 1;
        wr(8'h1E); wr(8'hE1);
        no_pulse(MAXT + 5, "R10 pulse suppressed");
        check(ovf_flag_o == 1, "R10 flag on suppressed overflow", ovf_flag_o, 1);
        rst_out_dis = 0;

        // Hardware reset disarms mid-count
        wr(8'h1E); wr(8'hE1); ticks(5);
        hw_reset();
        no_pulse(3 * MAXT, "R1 R6 hardware reset disarms");
        check(ovf_flag_o == 0, "R1 flag low after reset", ovf_flag_o, 0);

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule